// File: doc/BRIEF.md
# Serial Slave Port with Active-High Select

This block is the serial slave side of a link between a host microcontroller and a measurement device. The host drives a serial clock, a data line into the block and an active-high select line. The block drives one data line back, together with an enable for its tri-state pad. All three host lines are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and edge detection runs on the synchronized copies. The system clock must run at least four times faster than the serial clock.

A transfer starts when select rises and ends when select falls. At the select rise the block copies the parallel `tx_data` word into its transmit shifter and presents the most significant bit at once. On every rising serial-clock edge while select is high, the block captures one input bit and moves the next output bit onto the line. A frame counts only if exactly `FRAME_BITS` rising edges came before select fell. A complete frame is handed to the system side on a valid/ready output. The word is held there until it is accepted. If a frame completes while an earlier word is still waiting, the new word is dropped and the held word is left untouched.

Top module: `spi_hs_slave`

## Requirements
- R1: After reset, `sdo_oe` and `rx_valid` are low.
- R2: `sdo_oe` rises 3 system clocks after `sel_in` rises and falls 3 system clocks after `sel_in` falls. When it is low, `sdo_out` is 0.
- R3: `tx_data` is copied at the select rise, and its bit 31 appears on `sdo_out` together with `sdo_oe`. Changes to `tx_data` after that point have no effect on the frame in progress.
- R4: Each rising `sck_in` edge while select is high moves the next lower transmit bit onto `sdo_out`, so that a host sampling before each rising edge reads the copied word MSB first.
- R5: `sdi_in` is captured on each rising `sck_in` edge while select is high. The first captured bit becomes bit 31 of `rx_data`.
- R6: A frame with exactly 32 rising edges raises `rx_valid` 4 system clocks after `sel_in` falls, with `rx_data` equal to the received word.
- R7: A frame with fewer than 32 rising edges is discarded, and `rx_valid` stays low.
- R8: A frame with more than 32 rising edges is discarded, and `rx_valid` stays low.
- R9: While `rx_valid` is high and `rx_ready` is low, `rx_valid` and `rx_data` hold. A word is taken in a cycle where both are high, and `rx_valid` falls on the next clock unless a new word arrives in that same cycle.
- R10: A valid frame that completes while an unaccepted word is held is dropped, and `rx_data` keeps the older word.
- R11: `sck_in` and `sdi_in` activity while select is low has no effect. `sdo_oe` stays low, and the next frame is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_in | input | 1 | Serial clock from the host |
| sdi_in | input | 1 | Serial data from the host |
| sel_in | input | 1 | Active-high select from the host |
| sdo_out | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for the `sdo_out` pad |
| tx_data | input | 32 | Word sent in the next frame, copied at the select rise |
| rx_data | output | 32 | Received word |
| rx_valid | output | 1 | `rx_data` holds an unaccepted word |
| rx_ready | input | 1 | Consumer accepts the word |

## Verification
Each host-line change passes through two synchronizer stages and one edge register. Because of this, the pad enable and the transmit bit settle on the third system clock after a select or serial-clock edge, and `rx_valid` rises on the fourth clock after select falls. The bench drives all host lines on falling system-clock edges. In the directed timing test it samples `sdo_oe` and `rx_valid` one clock before and exactly at these due cycles. The serial-clock low and high phases last four system clocks each, so the bench reads `sdo_out` after every launch has settled and before the next rising edge.

// File: rtl/spi_hs_pkg.sv
`timescale 1ns/1ps
package spi_hs_pkg;
  localparam int unsigned FRAME_BITS_DEF = 32;
  localparam int unsigned SYNC_STAGES    = 2;
  // lanes of the synchronizer bank
  typedef enum int unsigned {
    LANE_SCK = 0,
    LANE_SDI = 1,
    LANE_SEL = 2,
    LANE_CNT = 3
  } lane_e;
endpackage

// File: rtl/spi_hs_sync.sv
`timescale 1ns/1ps
module spi_hs_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  for (genvar g = 0; g < W; g++) begin : g_lane
    logic [STAGES-1:0] chain;
    logic              last;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '0;
        last  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], async_in[g]};
        last  <= chain[STAGES-1];
      end
    end
    assign lvl[g]  = chain[STAGES-1];
    assign rise[g] = chain[STAGES-1] & ~last;
    assign fall[g] = ~chain[STAGES-1] & last;
  end
endmodule

// File: rtl/spi_hs_frame.sv
`timescale 1ns/1ps
module spi_hs_frame #(
  parameter int unsigned BITS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_lvl,
  input  logic            sel_rise,
  input  logic            sel_fall,
  input  logic            sck_rise,
  input  logic            sdi_lvl,
  input  logic [BITS-1:0] tx_word,
  output logic            busy,
  output logic            tx_bit,
  output logic            done,
  output logic [BITS-1:0] rx_word
);
  localparam int unsigned CW = $clog2(BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(BITS);

  logic [BITS-1:0] tx_sr;
  logic [BITS-1:0] rx_sr;
  logic [CW-1:0]   cnt;
  logic            over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      tx_sr <= '0;
      rx_sr <= '0;
      cnt   <= '0;
      over  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (sel_fall) begin
        busy <= 1'b0;
        if (busy && cnt == LAST && !over) done <= 1'b1;
      end else if (sel_rise) begin
        busy  <= 1'b1;
        tx_sr <= tx_word;
        cnt   <= '0;
        over  <= 1'b0;
      end else if (busy && sck_rise) begin
        rx_sr <= {rx_sr[BITS-2:0], sdi_lvl};
        tx_sr <= {tx_sr[BITS-2:0], 1'b0};
        if (cnt == LAST) over <= 1'b1;
        else             cnt  <= cnt + 1'b1;
      end
    end
  end

  assign tx_bit  = busy & tx_sr[BITS-1];
  assign rx_word = rx_sr;

  // R2: a low select leaves the pad released on the next clock
  a_r2_release_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_lvl |=> !busy);
  // R8: bit counter never passes the frame length
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R6: completion is a single-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11: while idle, serial clock edges leave the counter alone
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !sel_rise) |=> $stable(cnt));
endmodule

// File: rtl/spi_hs_rxhold.sv
`timescale 1ns/1ps
module spi_hs_rxhold #(
  parameter int unsigned BITS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_pulse,
  input  logic [BITS-1:0] in_word,
  output logic            out_valid,
  output logic [BITS-1:0] out_word,
  input  logic            out_ready
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (in_pulse && (!out_valid || out_ready)) begin
      out_valid <= 1'b1;
      out_word  <= in_word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9: a waiting word holds until taken
  a_r9_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));
  // R9: a taken word leaves when nothing new arrives
  a_r9_drop_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_pulse) |=> !out_valid);
  // R10: a new frame against a full slot leaves the slot unchanged
  a_r10_full_slot_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pulse && out_valid && !out_ready) |=> $stable(out_word));
endmodule

// File: rtl/spi_hs_slave.sv
`timescale 1ns/1ps
module spi_hs_slave
  import spi_hs_pkg::*;
#(
  parameter int unsigned FRAME_BITS = FRAME_BITS_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sck_in,
  input  logic                  sdi_in,
  input  logic                  sel_in,
  output logic                  sdo_out,
  output logic                  sdo_oe,
  input  logic [FRAME_BITS-1:0] tx_data,
  output logic [FRAME_BITS-1:0] rx_data,
  output logic                  rx_valid,
  input  logic                  rx_ready
);
  localparam int unsigned NL = LANE_CNT;

  logic [NL-1:0] raw, lvl, rise, fall;
  logic          done;
  logic [FRAME_BITS-1:0] rx_word;

  assign raw[LANE_SCK] = sck_in;
  assign raw[LANE_SDI] = sdi_in;
  assign raw[LANE_SEL] = sel_in;

  spi_hs_sync #(.W(NL), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(raw),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  spi_hs_frame #(.BITS(FRAME_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .sel_lvl(lvl[LANE_SEL]), .sel_rise(rise[LANE_SEL]), .sel_fall(fall[LANE_SEL]),
    .sck_rise(rise[LANE_SCK]), .sdi_lvl(lvl[LANE_SDI]),
    .tx_word(tx_data), .busy(sdo_oe), .tx_bit(sdo_out),
    .done(done), .rx_word(rx_word)
  );

  spi_hs_rxhold #(.BITS(FRAME_BITS)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_pulse(done), .in_word(rx_word),
    .out_valid(rx_valid), .out_word(rx_data), .out_ready(rx_ready)
  );
endmodule

// File: tb/sim_spi_hs_slave.sv
`timescale 1ns/1ps
module sim_spi_hs_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck_in = 1'b0, sdi_in = 1'b0, sel_in = 1'b0;
  logic        sdo_out, sdo_oe, rx_valid;
  logic        rx_ready = 1'b0;
  logic [31:0] tx_data = '0, rx_data;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_hs_slave u0 (
    .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .sdi_in(sdi_in), .sel_in(sel_in),
    .sdo_out(sdo_out), .sdo_oe(sdo_oe), .tx_data(tx_data), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  // {tx word, host word}
  localparam logic [63:0] VEC [4] = '{
    {32'hA5C3_0F17, 32'h1234_5678},
    {32'hFFFF_FFFF, 32'h0000_0000},
    {32'h0000_0001, 32'h8000_0000},
    {32'h6B2D_94E1, 32'hDEAD_BEEF}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Select high, nbits serial clocks, select low. Leaves sel low at a negedge.
  task automatic frame(input logic [31:0] tx, input logic [31:0] di, input int nbits,
                       output logic [31:0] got);
    got = '0;
    tx_data = tx;
    sel_in = 1'b1;
    tick(4);
    tx_data = ~tx;  // R3: late change must not matter
    for (int i = 0; i < nbits; i++) begin
      sdi_in = (i < 32) ? di[31-i] : 1'b0;
      tick(4);
      got = {got[30:0], sdo_out};
      sck_in = 1'b1;
      tick(4);
      sck_in = 1'b0;
    end
    tick(4);
    sel_in = 1'b0;
  endtask

  task automatic take();
    rx_ready = 1'b1;
    tick(1);
    rx_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    tick(3);
    // R1: reset state
    chk(sdo_oe == 1'b0 && rx_valid == 1'b0, "R1", {30'd0, sdo_oe, rx_valid}, 32'd0);
    rst_n = 1'b1;
    tick(2);

    // vector walk: R3 R4 R5 R6
    foreach (VEC[k]) begin
      frame(VEC[k][63:32], VEC[k][31:0], 32, got);
      tick(6);
      chk(got == VEC[k][63:32], "R4", got, VEC[k][63:32]);
      chk(rx_valid == 1'b1, "R6", {31'd0, rx_valid}, 32'd1);
      chk(rx_data == VEC[k][31:0], "R5", rx_data, VEC[k][31:0]);
      take();
      chk(rx_valid == 1'b0, "R9", {31'd0, rx_valid}, 32'd0);
    end

    // R2 / R3 / R6 exact timing
    tx_data = 32'h8000_0000;
    sel_in = 1'b1;
    tick(2);
    chk(sdo_oe == 1'b0, "R2", {31'd0, sdo_oe}, 32'd0);
    tick(1);
    chk(sdo_oe == 1'b1, "R2", {31'd0, sdo_oe}, 32'd1);
    chk(sdo_out == 1'b1, "R3", {31'd0, sdo_out}, 32'd1);
    for (int i = 0; i < 32; i++) begin
      sdi_in = i[0];
      tick(4); sck_in = 1'b1; tick(4); sck_in = 1'b0;
    end
    tick(4);
    sel_in = 1'b0;
    tick(2);
    chk(sdo_oe == 1'b1, "R2", {31'd0, sdo_oe}, 32'd1);
    tick(1);
    chk(sdo_oe == 1'b0 && sdo_out == 1'b0, "R2", {30'd0, sdo_oe, sdo_out}, 32'd0);
    chk(rx_valid == 1'b0, "R6", {31'd0, rx_valid}, 32'd0);
    tick(1);
    chk(rx_valid == 1'b1, "R6", {31'd0, rx_valid}, 32'd1);
    chk(rx_data == 32'h5555_5555, "R5", rx_data, 32'h5555_5555);
    take();

    // R7: short frame
    frame(32'h1111_1111, 32'hCAFE_F00D, 31, got);
    tick(8);
    chk(rx_valid == 1'b0, "R7", {31'd0, rx_valid}, 32'd0);

    // R8: long frame
    frame(32'h2222_2222, 32'hCAFE_F00D, 33, got);
    tick(8);
    chk(rx_valid == 1'b0, "R8", {31'd0, rx_valid}, 32'd0);

    // R11: serial activity with select low
    for (int i = 0; i < 5; i++) begin
      sdi_in = 1'b1; sck_in = 1'b1; tick(4);
      chk(sdo_oe == 1'b0, "R11", {31'd0, sdo_oe}, 32'd0);
      sck_in = 1'b0; tick(4);
    end
    frame(32'h0F0F_0F0F, 32'h0BAD_C0DE, 32, got);
    tick(6);
    chk(rx_valid && rx_data == 32'h0BAD_C0DE, "R11", rx_data, 32'h0BAD_C0DE);

    // R9 / R10: back-pressure, held word kept, newer frame dropped
    tick(20);
    chk(rx_valid && rx_data == 32'h0BAD_C0DE, "R9", rx_data, 32'h0BAD_C0DE);
    frame(32'h0, 32'h7777_1234, 32, got);
    tick(6);
    chk(rx_valid && rx_data == 32'h0BAD_C0DE, "R10", rx_data, 32'h0BAD_C0DE);
    take();
    chk(rx_valid == 1'b0, "R10", {31'd0, rx_valid}, 32'd0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule